// File: doc/BRIEF.md
# Wake-on-LAN Magic Frame Detector

This block sits beside a receive path and watches the bytes of each incoming Ethernet frame for a wake pattern. The pattern is a run of six 0xFF bytes followed at once by sixteen unbroken copies of the station's 48-bit address. It can start at any byte of the frame, and no protocol header beyond the destination address is decoded. A match is held internally. It turns into a wake event only when three things are true at the frame's last byte: the frame check passed, the destination address was acceptable, and the enable input is high.

The wake output is sticky. It stays set until the power-management logic pulses the clear input. Upstream logic delivers one byte per cycle when valid is high. It marks the first byte with a start flag, and it marks the last byte with an end flag together with a CRC-good flag. CRC computation is not part of this block.

Top module: `magic_wake_detector`

## Requirements
- R1: After reset, `wake` is low.
- R2: A frame with six 0xFF bytes followed directly by sixteen copies of `station_addr`, most significant byte first, raises `wake` in the cycle after its end-of-frame byte is accepted. `wake` stays low before that point.
- R3: The pattern is found at any byte offset. A run of more than six 0xFF bytes in front of the first address byte still counts as a valid synchronization run.
- R4: If a byte inside the address copies does not match, that same byte is evaluated again as a possible start of a new run. An 0xFF byte there counts as the first byte of a new sync run, so a valid pattern that overlaps a failed attempt is still found.
- R5: A frame holding only fifteen address copies after the sync run does not raise `wake`.
- R6: A frame that ends with `rx_crc_ok` low does not raise `wake`, even if it holds the pattern.
- R7: The destination address (the first six bytes) is accepted if it equals `station_addr` or if bit 0 of its first byte is 1 (multicast, which includes broadcast FF..FF). A frame whose destination is some other unicast address does not raise `wake`.
- R8: A frame whose end-of-frame byte arrives while `en` is low does not raise `wake`.
- R9: `wake` stays set until `wake_clr` is high at a clock edge, and it reads low in the cycle after that edge. If a qualifying end-of-frame byte arrives in the same cycle as the clear, the set takes priority.
- R10: A start-of-frame byte discards any match held from an earlier frame that ended without an end-of-frame marker.
- R11: Cycles with `rx_valid` low are ignored. Idle cycles between the bytes of a pattern do not break it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Detection enable |
| station_addr | input | 48 | Station address; bits 47:40 are sent first on the wire |
| rx_valid | input | 1 | `rx_data` carries a frame byte this cycle |
| rx_sof | input | 1 | First byte of a frame (qualified by `rx_valid`) |
| rx_eof | input | 1 | Last byte of a frame (qualified by `rx_valid`) |
| rx_data | input | 8 | Received byte |
| rx_crc_ok | input | 1 | Frame check passed; sampled with the end-of-frame byte |
| wake_clr | input | 1 | Clears the wake flag |
| wake | output | 1 | Sticky wake event |

## Verification
The bench targets the places where a scanner like this tends to fail.

- **Surplus 0xFF bytes before the addresses.** A sync counter that does not saturate would miss these.
- **A failed attempt followed at once by 0xFF.** A matcher that throws away the mismatching byte loses the first byte of the real sync run and stays silent.
- **A run one copy short.** A copy counter that is off by one would wake on it.
- **Gating at the frame's end.** A design that raised `wake` as soon as the pattern matched, or that ignored the CRC, enable or address-filter qualifiers, would produce wrong or early wake events.
- **Idle cycles, aborted frames, and clear-versus-set timing.** These catch a matcher that treats invalid cycles as data, keeps a match across a new start-of-frame, or drops a wake that coincides with a clear.

// File: rtl/magic_wake_detector.sv
module magic_wake_detector #(
  parameter int SYNC_LEN   = 6,
  parameter int REPS       = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic [7:0]              rx_data,
  input  logic                    rx_crc_ok,
  input  logic                    wake_clr,
  output logic                    wake
);
  localparam int FW = $clog2(SYNC_LEN + 1);
  localparam int BW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int RW = (REPS > 1) ? $clog2(REPS) : 1;
  localparam int PW = $clog2(ADDR_BYTES + 1);
  localparam logic [FW-1:0] FF_FULL  = FW'(SYNC_LEN);
  localparam logic [BW-1:0] B_LAST   = BW'(ADDR_BYTES - 1);
  localparam logic [RW-1:0] R_LAST   = RW'(REPS - 1);
  localparam logic [PW-1:0] DA_BYTES = PW'(ADDR_BYTES);

  logic          in_frame, in_addr, found, da_own, da_mc;
  logic [FW-1:0] ff_cnt;
  logic [BW-1:0] bsel;
  logic [RW-1:0] rep;
  logic [PW-1:0] pos;

  logic          in_addr_n, found_n, da_own_n, da_mc_n;
  logic [FW-1:0] ff_cnt_n;
  logic [BW-1:0] bsel_n;
  logic [RW-1:0] rep_n;
  logic [PW-1:0] pos_n;

  wire take  = rx_valid && (in_frame || rx_sof);
  wire is_ff = (rx_data == 8'hFF);

  function automatic logic [7:0] addr_byte(input int i);
    return station_addr[8*(ADDR_BYTES-1-i) +: 8];
  endfunction

  always_comb begin
    in_addr_n = rx_sof ? 1'b0 : in_addr;
    found_n   = rx_sof ? 1'b0 : found;
    da_own_n  = rx_sof ? 1'b1 : da_own;
    da_mc_n   = rx_sof ? 1'b0 : da_mc;
    ff_cnt_n  = rx_sof ? '0 : ff_cnt;
    bsel_n    = rx_sof ? '0 : bsel;
    rep_n     = rx_sof ? '0 : rep;
    pos_n     = rx_sof ? '0 : pos;

    if (pos_n != DA_BYTES) begin
      if (pos_n == '0) da_mc_n = rx_data[0];
      if (rx_data != addr_byte(int'(pos_n))) da_own_n = 1'b0;
      pos_n = pos_n + 1'b1;
    end

    if (in_addr_n && rx_data == addr_byte(int'(bsel_n))) begin
      if (bsel_n == B_LAST) begin
        bsel_n = '0;
        if (rep_n == R_LAST) begin
          found_n   = 1'b1;
          in_addr_n = 1'b0;
          rep_n     = '0;
        end else begin
          rep_n = rep_n + 1'b1;
        end
      end else begin
        bsel_n = bsel_n + 1'b1;
      end
    end else begin
      in_addr_n = 1'b0;
      bsel_n    = '0;
      rep_n     = '0;
      if (is_ff) begin
        if (ff_cnt_n != FF_FULL) ff_cnt_n = ff_cnt_n + 1'b1;
      end else if (ff_cnt_n == FF_FULL && rx_data == addr_byte(0)) begin
        ff_cnt_n  = '0;
        in_addr_n = 1'b1;
        bsel_n    = BW'(1);
      end else begin
        ff_cnt_n = '0;
      end
    end
  end

  wire hit = take && rx_eof && en && rx_crc_ok && found_n && (da_own_n || da_mc_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      in_addr  <= 1'b0;
      found    <= 1'b0;
      da_own   <= 1'b0;
      da_mc    <= 1'b0;
      ff_cnt   <= '0;
      bsel     <= '0;
      rep      <= '0;
      pos      <= '0;
      wake     <= 1'b0;
    end else begin
      if (take) begin
        in_frame <= !rx_eof;
        in_addr  <= in_addr_n;
        found    <= found_n;
        da_own   <= da_own_n;
        da_mc    <= da_mc_n;
        ff_cnt   <= ff_cnt_n;
        bsel     <= bsel_n;
        rep      <= rep_n;
        pos      <= pos_n;
      end
      if (hit)           wake <= 1'b1;
      else if (wake_clr) wake <= 1'b0;
    end
  end
endmodule

module magic_wake_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic rx_valid,
  input logic rx_eof,
  input logic rx_crc_ok,
  input logic wake_clr,
  input logic wake
);
  // R2
  wake_rise_at_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake) |-> $past(rx_valid && rx_eof && rx_crc_ok && en));

  // R6
  no_wake_bad_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake && !(rx_valid && rx_eof && rx_crc_ok)) |=> !wake);

  // R8
  no_wake_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake && !en) |=> !wake);

  // R9
  wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !wake_clr) |=> wake);

  // R9
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clr && !(rx_valid && rx_eof)) |=> !wake);
endmodule

bind magic_wake_detector magic_wake_detector_chk u_chk (.*);

// File: tb/magic_wake_detector_bench.sv
module magic_wake_detector_bench;
  logic clk = 0, rst_n = 0, en = 1, rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic rx_crc_ok = 0, wake_clr = 0, wake;
  logic [7:0]  rx_data = 0;
  logic [47:0] station_addr = 48'h112233445566;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  magic_wake_detector u_magic_wake_detector (.*);

  typedef struct packed {
    logic [1:0] da;      // 0 own, 1 broadcast, 2 multicast, 3 foreign unicast
    logic [3:0] pad;
    logic [2:0] xff;
    logic [4:0] copies;
    logic       crc;
    logic       en;
    logic       brk;
    logic       gap;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0,  3'd0, 5'd16, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2},  // R2
    '{2'd1, 4'd10, 3'd3, 5'd16, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{2'd2, 4'd3,  3'd0, 5'd16, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
    '{2'd3, 4'd3,  3'd0, 5'd16, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{2'd0, 4'd2,  3'd0, 5'd15, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{2'd0, 4'd2,  3'd0, 5'd16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{2'd0, 4'd2,  3'd0, 5'd16, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{2'd0, 4'd1,  3'd0, 5'd16, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4},  // R4
    '{2'd0, 4'd5,  3'd1, 5'd16, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd11}  // R11
  };

  logic [7:0] fr[$];

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: wake=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic put_addr(input int n);
    for (int c = 0; c < n; c++)
      for (int i = 0; i < 6; i++) fr.push_back(station_addr[8*(5-i) +: 8]);
  endtask

  task automatic build(input vec_t v, input bit with_seq);
    fr.delete();
    case (v.da)
      2'd0: put_addr(1);
      2'd1: for (int i = 0; i < 6; i++) fr.push_back(8'hFF);
      2'd2: begin fr.push_back(8'h01); fr.push_back(8'h00); fr.push_back(8'h5E);
                  fr.push_back(8'h00); fr.push_back(8'h00); fr.push_back(8'h01); end
      default: begin fr.push_back(8'h02); for (int i = 0; i < 4; i++) fr.push_back(8'h00);
                     fr.push_back(8'h09); end
    endcase
    fr.push_back(8'h02); fr.push_back(8'hAA); fr.push_back(8'hBB);
    fr.push_back(8'hCC); fr.push_back(8'hDD); fr.push_back(8'hEE);
    fr.push_back(8'h08); fr.push_back(8'h42);
    for (int i = 0; i < int'(v.pad); i++) fr.push_back(8'h5A);
    if (with_seq) begin
      if (v.brk) begin
        for (int i = 0; i < 6; i++) fr.push_back(8'hFF);
        put_addr(3);
      end
      for (int i = 0; i < 6 + int'(v.xff); i++) fr.push_back(8'hFF);
      put_addr(int'(v.copies));
    end
    for (int i = 0; i < 4; i++) fr.push_back(8'h33);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit sof, input bit eof,
                           input bit crc, input bit clr);
    @(negedge clk);
    rx_valid = 1; rx_data = b; rx_sof = sof; rx_eof = eof; rx_crc_ok = crc; wake_clr = clr;
    @(posedge clk); #1;
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_ok = 0; wake_clr = 0; rx_data = 8'h11;
  endtask

  task automatic send(input bit gap, input bit with_eof, input bit crc,
                      input bit clr_last, input bit pre_check, input string req);
    for (int i = 0; i < fr.size(); i++) begin
      bit last = (i == fr.size() - 1);
      if (gap && (i % 3 == 1)) @(negedge clk);
      if (pre_check && last) check(wake == 1'b0, req, wake, 1'b0);
      send_byte(fr[i], i == 0, last && with_eof, crc, last && clr_last);
    end
  endtask

  task automatic clear_wake(input string req);
    @(negedge clk); wake_clr = 1;
    @(posedge clk); #1; wake_clr = 0;
    check(wake == 1'b0, req, wake, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(wake == 1'b0, "R1", wake, 1'b0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    check(wake == 1'b0, "R1", wake, 1'b0);

    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      string rq = $sformatf("R%0d", v.req);
      en = v.en;
      build(v, 1'b1);
      send(v.gap, 1'b1, v.crc, 1'b0, v.exp, {rq, " pre-eof"});
      check(wake == v.exp, rq, wake, v.exp);
      en = 1;
      clear_wake("R9 clear");
    end

    // R9: sticky across a frame without the pattern
    build(VECS[0], 1'b1); send(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    check(wake == 1'b1, "R9 set", wake, 1'b1);
    build(VECS[0], 1'b0); send(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    check(wake == 1'b1, "R9 sticky", wake, 1'b1);
    clear_wake("R9 clear");

    // R9: a set at end of frame beats a simultaneous clear
    build(VECS[0], 1'b1); send(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    check(wake == 1'b1, "R9 set-wins", wake, 1'b1);
    clear_wake("R9 clear");

    // R10: a match in an unterminated frame is discarded by a new start
    build(VECS[0], 1'b1); send(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
    build(VECS[0], 1'b0); send(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
    check(wake == 1'b0, "R10", wake, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: wake=%0b expected=%0b", wake, 1'b0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule